// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block holds an interrupt redirection table with one 64-bit entry per input pin, reached through a pair of 32-bit registers on a simple bus slave port. Software first writes an index into the select register at byte offset 0x00. It then reads or writes the selected internal register through the data window at byte offset 0x10. The internal registers are an identity register, a read-only version register, an arbitration register, and the two 32-bit halves of every redirection entry.

Every field of every entry is driven in parallel on the output ports, so delivery logic can see the whole table at once. Delivery logic sets the pending-acknowledge (remote IRR) bit of a pin through a set vector. End-of-interrupt handling clears it through a clear vector. After every bus write to an entry, the block pulses a strobe that carries the pin number, so that delivery logic can re-evaluate that pin.

Top module: `irq_redir_regwin`

## Requirements
- R1: After reset, every entry reads low half 0x00010000 and high half 0x00010000, so every pin is masked (mask = low-half bit 16). The identity register and the select register read 0.
- R2: A write to byte offset 0x00 keeps only bits 7:0 of the data in the select register. A read of offset 0x00 returns that value, zero-extended.
- R3: An access whose size code is not 2 (req_size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes) gets rsp_error = 1 and rsp_rdata = 0, and changes no state.
- R4: A 32-bit read of any offset other than 0x00 and 0x10 returns 0xFFFFFFFF. A 32-bit write to such an offset has no effect.
- R5: Index 0x00 is the identity register, and a write keeps only data bits 27:24. Index 0x02 (arbitration) reads the identity value. Index 0x01 (version) reads 0x11 in bits 7:0 and NUM_PINS-1 in bits 23:16. Writes to indices 0x01 and 0x02 are ignored.
- R6: Pin n's entry sits at index 0x10+2n (low half) and 0x11+2n (high half). Its fields are: vector [7:0], delivery mode [10:8], destination mode [11], delivery status [12], polarity [13], remote IRR [14], trigger mode [15] (1 = level), mask [16] and destination [63:56]. Each field is driven on the pin_* outputs. Any index that is not listed here, including those from 0x10+2*NUM_PINS upward, reads 0.
- R7: A write to a low half keeps the stored bits 12 and 14 and replaces every other bit with the written data.
- R8: When an entry is in edge mode (bit 15 = 0) after a write, its remote IRR bit reads 0.
- R9: A one-cycle pulse on irr_set[n] sets remote IRR of pin n only if that pin is in level mode. A pulse on irr_clr[n] clears it.
- R10: Every 32-bit window write to an entry index pulses upd_valid for one cycle, together with the response, with upd_pin = n. No other access pulses upd_valid.
- R11: Every request yields exactly one response: rsp_valid goes high in the cycle after req_valid, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_size | input | 2 | Access size code (2 = 32-bit) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_error | output | 1 | Access rejected for its size |
| rsp_rdata | output | 32 | Read data |
| irr_set | input | NUM_PINS | Per-pin request to set remote IRR |
| irr_clr | input | NUM_PINS | Per-pin request to clear remote IRR |
| upd_valid | output | 1 | Entry-changed strobe |
| upd_pin | output | PIN_W | Pin whose entry was written |
| pin_vector | output | 8*NUM_PINS | Vector of each pin |
| pin_delmode | output | 3*NUM_PINS | Delivery mode of each pin |
| pin_destmode | output | NUM_PINS | Destination mode of each pin |
| pin_polarity | output | NUM_PINS | Polarity of each pin |
| pin_level | output | NUM_PINS | Trigger mode of each pin (1 = level) |
| pin_irr | output | NUM_PINS | Remote IRR of each pin |
| pin_mask | output | NUM_PINS | Mask of each pin |
| pin_dest | output | 8*NUM_PINS | Destination of each pin |

## Verification
Each bus response, and its strobe when there is one, is registered at the clock edge that samples the request, so both are due exactly one cycle after the request. The monitor samples them on the following falling edge, pops the expected item that the driver queued for that request, and flags any response that arrives with nothing expected. A state change made by a bus write or by an irr pulse is visible on the pin_* outputs, and on the next read, from the first falling edge after the edge that took it. The field checks are placed there.

// File: rtl/irw_pkg.sv
package irw_pkg;
  localparam int unsigned SEL_OFS   = 0;
  localparam int unsigned WIN_OFS   = 16;
  localparam int unsigned SIZE_W32  = 2;
  localparam int unsigned IDX_ID    = 0;
  localparam int unsigned IDX_VER   = 1;
  localparam int unsigned IDX_ARB   = 2;
  localparam int unsigned IDX_TBL   = 16;
  localparam logic [7:0]  VER_CODE  = 8'h11;
  localparam logic [31:0] ID_KEEP   = 32'h0F00_0000;
  localparam int unsigned B_DSTAT   = 12;
  localparam int unsigned B_IRR     = 14;
  localparam int unsigned B_TRIG    = 15;
  localparam int unsigned B_MASK    = 16;
  localparam logic [31:0] LO_RO     = (32'h1 << B_DSTAT) | (32'h1 << B_IRR);
  localparam logic [31:0] LO_RST    = 32'h0001_0000;
  localparam logic [31:0] HI_RST    = 32'h0001_0000;

  function automatic logic [31:0] merge_lo(input logic [31:0] old_v, input logic [31:0] wd);
    return (old_v & LO_RO) | (wd & ~LO_RO);
  endfunction
endpackage

// File: rtl/irw_bus_decode.sv
module irw_bus_decode
  import irw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              size_bad,
  output logic              hit_sel,
  output logic              hit_win
);
  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(SEL_OFS);
  localparam logic [ADDR_W-1:0] A_WIN = ADDR_W'(WIN_OFS);

  always_comb begin
    size_bad = (size != 2'(SIZE_W32));
    hit_sel  = !size_bad && (addr == A_SEL);
    hit_win  = !size_bad && (addr == A_WIN);
  end
endmodule

// File: rtl/irw_entry_bank.sv
module irw_entry_bank
  import irw_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  localparam int unsigned PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       wr_hi,
  input  logic [PIN_W-1:0]           wr_pin,
  input  logic [31:0]                wdata,
  input  logic [NUM_PINS-1:0]        irr_set,
  input  logic [NUM_PINS-1:0]        irr_clr,
  output logic [NUM_PINS-1:0][31:0]  lo_tbl,
  output logic [NUM_PINS-1:0][31:0]  hi_tbl
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [31:0] lo_q, hi_q, lo_n, hi_n;
    logic        hit;

    always_comb begin
      hit  = wr_en && (wr_pin == PIN_W'(i));
      lo_n = lo_q;
      hi_n = hi_q;
      if (hit && !wr_hi) begin
        lo_n = merge_lo(lo_q, wdata);
      end else if (hit && wr_hi) begin
        hi_n = wdata;
      end else begin
        if (irr_set[i] && lo_q[B_TRIG]) lo_n[B_IRR] = 1'b1;
        if (irr_clr[i])                 lo_n[B_IRR] = 1'b0;
      end
      if (!lo_n[B_TRIG]) lo_n[B_IRR] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q <= LO_RST;
        hi_q <= HI_RST;
      end else begin
        lo_q <= lo_n;
        hi_q <= hi_n;
      end
    end

    assign lo_tbl[i] = lo_q;
    assign hi_tbl[i] = hi_q;

    // R8: an edge-mode entry never shows a pending acknowledge
    p_edge_no_irr_r8: assert property (@(posedge clk) disable iff (rst)
      !lo_q[B_TRIG] |-> !lo_q[B_IRR]);
    // R7: a bus write to the low half leaves delivery status untouched
    p_lo_ro_keep_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_hi && wr_pin == PIN_W'(i)) |=> lo_q[B_DSTAT] == $past(lo_q[B_DSTAT]));
    // R9: a set request on a level pin with no competing update sets remote IRR
    p_irr_set_r9: assert property (@(posedge clk) disable iff (rst)
      (irr_set[i] && !irr_clr[i] && lo_q[B_TRIG] && !(wr_en && wr_pin == PIN_W'(i)))
      |=> lo_q[B_IRR]);
  end
endmodule

// File: rtl/irw_read_mux.sv
module irw_read_mux
  import irw_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  localparam int unsigned PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic [7:0]                 sel,
  input  logic [31:0]                id_val,
  input  logic [NUM_PINS-1:0][31:0]  lo_tbl,
  input  logic [NUM_PINS-1:0][31:0]  hi_tbl,
  output logic                       in_tbl,
  output logic [PIN_W-1:0]           tbl_pin,
  output logic [31:0]                rd_val
);
  localparam int unsigned TBL_END = IDX_TBL + 2 * NUM_PINS;
  localparam logic [7:0]  MAXENT  = 8'(NUM_PINS - 1);
  localparam logic [31:0] VER_VAL = {8'h00, MAXENT, 8'h00, VER_CODE};

  logic [8:0] rel;

  always_comb begin
    rel     = {1'b0, sel} - 9'(IDX_TBL);
    in_tbl  = ({1'b0, sel} >= 9'(IDX_TBL)) && ({1'b0, sel} < 9'(TBL_END));
    tbl_pin = PIN_W'(rel[8:1]);
    rd_val  = 32'h0;
    if (sel == 8'(IDX_ID) || sel == 8'(IDX_ARB)) rd_val = id_val;
    else if (sel == 8'(IDX_VER))                 rd_val = VER_VAL;
    else if (in_tbl)                             rd_val = sel[0] ? hi_tbl[tbl_pin] : lo_tbl[tbl_pin];
  end
endmodule

// File: rtl/irq_redir_regwin.sv
module irq_redir_regwin
  import irw_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned ADDR_W   = 8,
  localparam int unsigned PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [1:0]             req_size,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  output logic                   rsp_error,
  output logic [31:0]            rsp_rdata,
  input  logic [NUM_PINS-1:0]    irr_set,
  input  logic [NUM_PINS-1:0]    irr_clr,
  output logic                   upd_valid,
  output logic [PIN_W-1:0]       upd_pin,
  output logic [8*NUM_PINS-1:0]  pin_vector,
  output logic [3*NUM_PINS-1:0]  pin_delmode,
  output logic [NUM_PINS-1:0]    pin_destmode,
  output logic [NUM_PINS-1:0]    pin_polarity,
  output logic [NUM_PINS-1:0]    pin_level,
  output logic [NUM_PINS-1:0]    pin_irr,
  output logic [NUM_PINS-1:0]    pin_mask,
  output logic [8*NUM_PINS-1:0]  pin_dest
);
  logic                      size_bad, hit_sel, hit_win;
  logic [7:0]                sel_q;
  logic [31:0]               id_q;
  logic [NUM_PINS-1:0][31:0] lo_tbl, hi_tbl;
  logic                      in_tbl;
  logic [PIN_W-1:0]          tbl_pin;
  logic [31:0]               win_val;
  logic                      wr_win, tbl_wr;

  irw_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .size(req_size),
    .size_bad(size_bad), .hit_sel(hit_sel), .hit_win(hit_win)
  );

  irw_read_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .sel(sel_q), .id_val(id_q), .lo_tbl(lo_tbl), .hi_tbl(hi_tbl),
    .in_tbl(in_tbl), .tbl_pin(tbl_pin), .rd_val(win_val)
  );

  assign wr_win = req_valid && req_write && hit_win;
  assign tbl_wr = wr_win && in_tbl;

  irw_entry_bank #(.NUM_PINS(NUM_PINS)) u_bank (
    .clk(clk), .rst(rst), .wr_en(tbl_wr), .wr_hi(sel_q[0]), .wr_pin(tbl_pin),
    .wdata(req_wdata), .irr_set(irr_set), .irr_clr(irr_clr),
    .lo_tbl(lo_tbl), .hi_tbl(hi_tbl)
  );

  // select, identity and response registers
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      id_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_error <= 1'b0;
      rsp_rdata <= '0;
      upd_valid <= 1'b0;
      upd_pin   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_error <= req_valid && size_bad;
      upd_valid <= tbl_wr;
      if (tbl_wr) upd_pin <= tbl_pin;
      if (req_valid && req_write && hit_sel) sel_q <= req_wdata[7:0];
      if (wr_win && sel_q == 8'(IDX_ID))     id_q  <= req_wdata & ID_KEEP;
      if (req_valid) begin
        if (size_bad || req_write) rsp_rdata <= '0;
        else if (hit_sel)          rsp_rdata <= {24'h0, sel_q};
        else if (hit_win)          rsp_rdata <= win_val;
        else                       rsp_rdata <= 32'hFFFF_FFFF;
      end
    end
  end

  // per-pin field outputs straight from the table registers
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_out
    assign pin_vector[8*i +: 8]  = lo_tbl[i][7:0];
    assign pin_delmode[3*i +: 3] = lo_tbl[i][10:8];
    assign pin_destmode[i]       = lo_tbl[i][11];
    assign pin_polarity[i]       = lo_tbl[i][13];
    assign pin_irr[i]            = lo_tbl[i][B_IRR];
    assign pin_level[i]          = lo_tbl[i][B_TRIG];
    assign pin_mask[i]           = lo_tbl[i][B_MASK];
    assign pin_dest[8*i +: 8]    = hi_tbl[i][31:24];
  end

  // R11: one response per request, exactly one cycle later
  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_rsp_nospur_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R3: rejected access returns no data and leaves the select register alone
  p_err_zero_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_error |-> (rsp_rdata == 32'h0 && rsp_valid));
  p_err_nosel_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && size_bad) |=> $stable(sel_q));
  // R10: the strobe only follows a window write
  p_upd_src_r10: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> ($past(req_valid) && $past(req_write) && !rsp_error));
  // R5: identity keeps nothing outside its four bits
  p_id_bits_r5: assert property (@(posedge clk) disable iff (rst)
    (id_q & ~ID_KEEP) == 32'h0);
endmodule

// File: tb/sim_irq_redir_regwin.sv
`timescale 1ns/1ps
module sim_irq_redir_regwin;
  localparam int N = 24;
  localparam int PW = $clog2(N);

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = '0;
  logic [1:0] req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_error, upd_valid;
  logic [31:0] rsp_rdata;
  logic [N-1:0] irr_set = '0, irr_clr = '0;
  logic [PW-1:0] upd_pin;
  logic [8*N-1:0] pin_vector, pin_dest;
  logic [3*N-1:0] pin_delmode;
  logic [N-1:0] pin_destmode, pin_polarity, pin_level, pin_irr, pin_mask;

  always #4 clk = ~clk;

  irq_redir_regwin #(.NUM_PINS(N), .ADDR_W(8)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .irr_set(irr_set), .irr_clr(irr_clr), .upd_valid(upd_valid), .upd_pin(upd_pin),
    .pin_vector(pin_vector), .pin_delmode(pin_delmode), .pin_destmode(pin_destmode),
    .pin_polarity(pin_polarity), .pin_level(pin_level), .pin_irr(pin_irr),
    .pin_mask(pin_mask), .pin_dest(pin_dest)
  );

  typedef struct {
    logic [31:0] rd;
    logic        err;
    logic        upd;
    int          pin;
    string       tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per response (R11)
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q.size() == 0) begin
        total++; bad++;
        $display("FAIL R11 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " rdata"}, rsp_rdata, e.rd);
        check({e.tag, " error"}, 32'(rsp_error), 32'(e.err));
        check({e.tag, " R10 strobe"}, 32'(upd_valid), 32'(e.upd));
        if (e.upd) check({e.tag, " R10 pin"}, 32'(upd_pin), 32'(e.pin));
      end
    end else if (!rst && upd_valid) begin
      total++; bad++;
      $display("FAIL R10 strobe without response actual=1 expected=0");
    end
  end

  task automatic bus(input logic wr, input logic [7:0] a, input logic [1:0] sz,
                     input logic [31:0] d, input logic [31:0] erd, input logic eerr,
                     input logic eupd, input int epin, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    e.rd = erd; e.err = eerr; e.upd = eupd; e.pin = epin; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wr_idx(input logic [7:0] idx, input logic [31:0] d, input logic eupd,
                        input int epin, input string tag);
    bus(1, 8'h00, 2, 32'(idx), 0, 0, 0, 0, tag);
    bus(1, 8'h10, 2, d, 0, 0, eupd, epin, tag);
  endtask

  task automatic rd_idx(input logic [7:0] idx, input logic [31:0] exp, input string tag);
    bus(1, 8'h00, 2, 32'(idx), 0, 0, 0, 0, tag);
    bus(0, 8'h10, 2, 0, exp, 0, 0, 0, tag);
  endtask

  task automatic pulse(input bit set, input int p);
    @(negedge clk);
    if (set) irr_set[p] = 1'b1; else irr_clr[p] = 1'b1;
    @(negedge clk);
    irr_set = '0; irr_clr = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 masks", 32'(pin_mask), 32'(24'hFFFFFF));
    check("R1 irr", 32'(pin_irr), 0);
    bus(0, 8'h00, 2, 0, 32'h0, 0, 0, 0, "R1 select");
    bus(0, 8'h10, 2, 0, 32'h0, 0, 0, 0, "R1 identity");
    rd_idx(8'h10, 32'h0001_0000, "R1 pin0 low");
    rd_idx(8'h3F, 32'h0001_0000, "R1 pin23 high");
    // R2 select keeps low byte
    bus(1, 8'h00, 2, 32'h1234_56AB, 0, 0, 0, 0, "R2 write");
    bus(0, 8'h00, 2, 0, 32'h0000_00AB, 0, 0, 0, "R2 readback");
    // R3 bad sizes
    bus(1, 8'h00, 1, 32'h0000_0002, 0, 1, 0, 0, "R3 half write");
    bus(0, 8'h00, 0, 0, 0, 1, 0, 0, "R3 byte read");
    bus(0, 8'h00, 2, 0, 32'h0000_00AB, 0, 0, 0, "R3 select kept");
    // R4 other offsets
    bus(0, 8'h04, 2, 0, 32'hFFFF_FFFF, 0, 0, 0, "R4 read 0x04");
    bus(1, 8'h08, 2, 32'h0000_0001, 0, 0, 0, 0, "R4 write 0x08");
    bus(0, 8'h00, 2, 0, 32'h0000_00AB, 0, 0, 0, "R4 select kept");
    // R5 identity, version, arbitration
    wr_idx(8'h00, 32'hFFFF_FFFF, 0, 0, "R5 id write");
    rd_idx(8'h00, 32'h0F00_0000, "R5 id read");
    rd_idx(8'h02, 32'h0F00_0000, "R5 arb read");
    rd_idx(8'h01, 32'h0017_0011, "R5 version");
    wr_idx(8'h01, 32'h1234_5678, 0, 0, "R5 version write");
    wr_idx(8'h02, 32'h0000_0000, 0, 0, "R5 arb write");
    rd_idx(8'h01, 32'h0017_0011, "R5 version kept");
    rd_idx(8'h00, 32'h0F00_0000, "R5 id kept");
    // R6 entry layout for pin 3 (index 0x16/0x17)
    wr_idx(8'h16, 32'h0000_AB35, 1, 3, "R6 pin3 low");
    wr_idx(8'h17, 32'hAB00_0000, 1, 3, "R6 pin3 high");
    check("R6 vector", 32'(pin_vector[8*3 +: 8]), 32'h35);
    check("R6 delmode", 32'(pin_delmode[3*3 +: 3]), 32'h3);
    check("R6 destmode", 32'(pin_destmode[3]), 1);
    check("R6 polarity", 32'(pin_polarity[3]), 1);
    check("R6 level", 32'(pin_level[3]), 1);
    check("R6 mask", 32'(pin_mask[3]), 0);
    check("R6 dest", 32'(pin_dest[8*3 +: 8]), 32'hAB);
    rd_idx(8'h16, 32'h0000_AB35, "R6 low read");
    rd_idx(8'h17, 32'hAB00_0000, "R6 high read");
    rd_idx(8'h40, 32'h0, "R6 beyond table");
    rd_idx(8'h08, 32'h0, "R6 unused index");
    // R9 set on a level pin
    pulse(1, 3);
    check("R9 irr set", 32'(pin_irr[3]), 1);
    rd_idx(8'h16, 32'h0000_EB35, "R9 low with irr");
    // R7 low write keeps bits 12 and 14
    wr_idx(8'h16, 32'h0000_9036, 1, 3, "R7 low write");
    rd_idx(8'h16, 32'h0000_C036, "R7 ro kept");
    // R8 going to edge clears remote IRR
    wr_idx(8'h16, 32'h0000_0036, 1, 3, "R8 edge write");
    check("R8 irr cleared", 32'(pin_irr[3]), 0);
    rd_idx(8'h16, 32'h0000_0036, "R8 low read");
    pulse(1, 3);
    check("R9 set ignored in edge", 32'(pin_irr[3]), 0);
    wr_idx(8'h16, 32'h0000_8036, 1, 3, "R9 back to level");
    pulse(1, 3);
    check("R9 irr set again", 32'(pin_irr[3]), 1);
    pulse(0, 3);
    check("R9 irr cleared", 32'(pin_irr[3]), 0);
    // R10 strobe for the last pin, high half
    wr_idx(8'h3F, 32'h5500_0000, 1, 23, "R10 pin23 high");
    check("R10 pin23 dest", 32'(pin_dest[8*23 +: 8]), 32'h55);
    check("R10 pin23 still masked", 32'(pin_mask[23]), 1);
    repeat (4) @(negedge clk);
    check("R11 all responses seen", 32'(q.size()), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule